// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

The arbiter holds one pending flag per interrupt source and picks a single winner to hand to a processor core. Peripherals raise flags with one-cycle pulses. Software drops flags through a clear port. Each source has its own enable bit. Maskable sources also need the global enable, while a small parameter-selected group of non-maskable sources ignores it. The winner is always the highest-indexed eligible flag, which also gives the highest vector address. The arbiter drives that vector's word address with a valid strobe and holds both until the core acknowledges.

Acceptance is the cycle in which valid and acknowledge are both high. In that cycle the arbiter pulses a request telling the core to drop its global enable. If the winning source is marked single-source, its flag is cleared on that same edge. Flags of multi-source requests stay set until software clears them. One source can also be set from an external pin. The pin is synchronized, and only its rising edges set the flag.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is held, and on release, all flags are zero and `vec_valid` is low.
- R2: Source i (0 to N-1, default N=15) presents vector address 0xFFE0 + 2*(i+1), so source 0 gives 0xFFE2 and source 14 gives 0xFFFE.
- R3: When several sources are eligible in the cycle a vector is chosen, the highest index wins. Lower ones are presented afterwards, one at a time.
- R4: A maskable source (default indices 0 to 11) is eligible only when its flag, its `src_en` bit and `gie` are all 1.
- R5: A non-maskable source (default indices 12, 13 and 14) is eligible when its flag and its `src_en` bit are 1, whatever the value of `gie`.
- R6: From the first cycle `vec_valid` is high until the acknowledge cycle, `vec_addr` does not change, even when higher-priority requests arrive.
- R7: On acceptance, a single-source flag (default indices 4 to 14) is cleared. A multi-source flag (default indices 0 to 3) stays set and is presented again.
- R8: `gie_clr` is high exactly in cycles where `vec_valid` and `vec_ack` are both high. After such a cycle `vec_valid` is low for at least one cycle.
- R9: `sw_clr_en` with `sw_clr_mask` clears the masked flags on the next edge. A pulse and a clear on the same flag in the same cycle leave it set.
- R10: A rising edge on `nmi_pin` sets the flag of source 14 three edges later, after a two-flop synchronizer and an edge detector. Holding the pin high does not set the flag again.
- R11: A pulse sampled at edge E sets the flag after E. If the source is eligible and no vector is held, `vec_valid` rises after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | N | One-cycle set pulses, one per source |
| nmi_pin | input | 1 | Asynchronous pin whose rising edge sets source 14 |
| sw_clr_en | input | 1 | Software clear strobe |
| sw_clr_mask | input | N | Flags to clear when the strobe is high |
| src_en | input | N | Per-source enable bits |
| gie | input | 1 | Global enable for maskable sources |
| flags | output | N | Pending flags |
| vec_valid | output | 1 | A vector is presented |
| vec_addr | output | AW | Word address of the presented vector |
| vec_ack | input | 1 | Core accepts the presented vector |
| gie_clr | output | 1 | Core must clear its global enable |

## Verification
The arbiter is driven in several ways:
- single pulses on lone sources, to confirm the address formula;
- several pulses in one cycle, which must drain in descending index order;
- flags raised while `gie` or an enable bit is low, which separates maskable from non-maskable gating;
- a request that arrives while a vector is held unacknowledged, to show the presented vector is not preempted.

Multi-source and single-source sources are acknowledged the same way, so the difference between auto-clear and re-presentation is visible. The pin is raised, held high and raised again, which separates edge detection from level sensing. A pulse and a clear given in the same cycle confirm that the set has precedence.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N = 15,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFE0,
  parameter logic [N-1:0] NMI_MASK = 15'h7000,
  parameter logic [N-1:0] SINGLE_MASK = 15'h7FF0,
  parameter int PIN_SRC = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_pulse,
  input  logic          nmi_pin,
  input  logic          sw_clr_en,
  input  logic [N-1:0]  sw_clr_mask,
  input  logic [N-1:0]  src_en,
  input  logic          gie,
  output logic [N-1:0]  flags,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  input  logic          vec_ack,
  output logic          gie_clr
);
  localparam int SW = $clog2(N);

  logic [2:0]    pin_q;
  logic          pin_rise;
  logic [N-1:0]  set_v, auto_clr, drop_v, eligible;
  logic [SW-1:0] sel, win;
  logic          accept;

  assign pin_rise = pin_q[1] & ~pin_q[2];
  assign set_v    = src_pulse | (N'(pin_rise) << PIN_SRC);
  assign accept   = vec_valid & vec_ack;
  assign gie_clr  = accept;
  assign auto_clr = (accept && SINGLE_MASK[sel]) ? (N'(1) << sel) : '0;
  assign drop_v   = (sw_clr_en ? sw_clr_mask : '0) | auto_clr;
  assign eligible = flags & src_en & (NMI_MASK | {N{gie}});
  assign vec_addr = VEC_BASE + (AW'(sel) << 1) + AW'(2);

  always_comb begin
    win = '0;
    for (int i = 0; i < N; i++)
      if (eligible[i]) win = SW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= '0;
      flags     <= '0;
      vec_valid <= 1'b0;
      sel       <= '0;
    end else begin
      pin_q <= {pin_q[1:0], nmi_pin};
      flags <= (flags & ~drop_v) | set_v;
      if (accept)
        vec_valid <= 1'b0;
      else if (!vec_valid && |eligible) begin
        vec_valid <= 1'b1;
        sel       <= win;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N = 15,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFE0,
  parameter logic [N-1:0] NMI_MASK = 15'h7000,
  parameter logic [N-1:0] SINGLE_MASK = 15'h7FF0,
  parameter int PIN_SRC = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  src_pulse,
  input logic          nmi_pin,
  input logic          sw_clr_en,
  input logic [N-1:0]  sw_clr_mask,
  input logic [N-1:0]  src_en,
  input logic          gie,
  input logic [N-1:0]  flags,
  input logic          vec_valid,
  input logic [AW-1:0] vec_addr,
  input logic          vec_ack,
  input logic          gie_clr
);
  logic [AW-1:0] off;
  logic [N-1:0]  elig_c, idx_bit, above;
  logic          idx_ok;

  assign off     = (vec_addr - VEC_BASE) >> 1;
  assign idx_ok  = (off >= AW'(1)) && (off <= AW'(N));
  assign idx_bit = idx_ok ? (N'(1) << (off - AW'(1))) : '0;
  assign above   = ~((idx_bit << 1) - N'(1)) & ~idx_bit;
  assign elig_c  = flags & src_en & (NMI_MASK | {N{gie}});

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && !vec_valid));

  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> idx_ok && vec_addr[0] == 1'b0);

  p_highest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ($past(elig_c) & above) == '0);

  p_winner_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ($past(elig_c) & idx_bit) != '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ack) |=> vec_valid && $stable(vec_addr));

  p_autoclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ack && (idx_bit & SINGLE_MASK) != '0 &&
     (idx_bit & src_pulse) == '0 && (idx_bit & (N'(1) << PIN_SRC)) == '0)
    |=> (flags & $past(idx_bit)) == '0);

  p_gie_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !vec_valid);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> (flags & $past(src_pulse)) == $past(src_pulse));
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .N(N), .AW(AW), .VEC_BASE(VEC_BASE), .NMI_MASK(NMI_MASK),
  .SINGLE_MASK(SINGLE_MASK), .PIN_SRC(PIN_SRC)
) u_chk (.*);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int N = 15;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_pulse = '0, src_en = '1, tb_mask = '0, mon_mask = '0;
  logic nmi_pin = 0, gie = 1, tb_clr = 0, mon_clr = 0, mon_ack = 0;
  logic auto_ack = 0;
  logic [N-1:0] flags;
  logic vec_valid, gie_clr;
  logic [15:0] vec_addr, e;
  bit c;
  int checks = 0, errors = 0;
  logic [15:0] q_addr[$];
  bit q_clr[$];

  always #4 clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .nmi_pin(nmi_pin),
    .sw_clr_en(tb_clr | mon_clr), .sw_clr_mask(tb_mask | mon_mask),
    .src_en(src_en), .gie(gie), .flags(flags), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .vec_ack(mon_ack), .gie_clr(gie_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] va(input int i);
    return 16'hFFE0 + 16'(2 * (i + 1));
  endfunction

  task automatic expect_vec(input int i, input bit clr);
    q_addr.push_back(va(i));
    q_clr.push_back(clr);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_pulse = m;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 200 && q_addr.size() != 0; k++) @(negedge clk);
    chk(q_addr.size() == 0, req, q_addr.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor: pops expected vectors and acknowledges them
  always @(negedge clk) begin
    mon_ack = 0; mon_clr = 0; mon_mask = '0;
    if (rst_n && auto_ack && vec_valid) begin
      if (q_addr.size() == 0) begin
        chk(0, "R3 unexpected vector", vec_addr, 0);
        mon_ack = 1;
      end else begin
        e = q_addr.pop_front();
        c = q_clr.pop_front();
        chk(vec_addr == e, "R2/R3 vector order", vec_addr, e);
        mon_ack = 1;
        if (c) begin
          mon_clr = 1;
          mon_mask = N'(1) << ((e - 16'hFFE0) / 2 - 1);
        end
        #1 chk(gie_clr == 1'b1, "R8 gie_clr on accept", gie_clr, 1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(flags == '0 && !vec_valid, "R1 reset state", {flags, vec_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(flags == '0 && !vec_valid, "R1 after release", {flags, vec_valid}, 0);

    // R11 latency, then R2 address of source 9
    pulse(N'(1) << 9);
    chk(flags[9] && !vec_valid, "R11 flag set, valid not yet", {flags[9], vec_valid}, 2'b10);
    @(negedge clk);
    chk(vec_valid && vec_addr == va(9), "R11 valid one cycle after flag", vec_addr, va(9));
    chk(!gie_clr, "R8 no gie_clr without ack", gie_clr, 0);
    expect_vec(9, 0);
    auto_ack = 1;
    drain("R2 source 9 served");
    chk(!flags[9], "R7 single-source auto-clear", flags[9], 0);

    // R2 single source 5
    expect_vec(5, 0);
    pulse(N'(1) << 5);
    drain("R2 source 5 served");
    chk(!flags[5], "R7 source 5 cleared", flags[5], 0);

    // R3 three at once, multi-source 2 cleared by software at accept
    expect_vec(10, 0); expect_vec(7, 0); expect_vec(2, 1);
    pulse((N'(1) << 2) | (N'(1) << 7) | (N'(1) << 10));
    drain("R3 priority drain");
    chk(flags == '0, "R3 all flags consumed", flags, 0);

    // R7 multi-source stays set and is presented again
    expect_vec(1, 0); expect_vec(1, 1);
    pulse(N'(1) << 1);
    drain("R7 multi-source presented twice");
    chk(!flags[1], "R7 multi-source cleared by software", flags[1], 0);

    // R4 maskable gating
    gie = 0;
    pulse(N'(1) << 6);
    repeat (5) @(negedge clk);
    chk(!vec_valid && flags[6], "R4 gie low blocks maskable", {vec_valid, flags[6]}, 1);
    src_en[6] = 0; gie = 1;
    repeat (5) @(negedge clk);
    chk(!vec_valid, "R4 enable low blocks maskable", vec_valid, 0);
    expect_vec(6, 0);
    src_en[6] = 1;
    drain("R4 released when both enables set");

    // R5 non-maskable ignores gie, obeys own enable
    gie = 0;
    src_en[13] = 0;
    pulse(N'(1) << 13);
    repeat (5) @(negedge clk);
    chk(!vec_valid && flags[13], "R5 own enable blocks non-maskable", {vec_valid, flags[13]}, 1);
    tb_clr = 1; tb_mask = N'(1) << 13;
    @(negedge clk);
    tb_clr = 0; tb_mask = '0;
    src_en[13] = 1;
    expect_vec(12, 0);
    pulse(N'(1) << 12);
    drain("R5 non-maskable with gie low");
    gie = 1;

    // R6 hold while unacknowledged
    auto_ack = 0;
    pulse(N'(1) << 3);
    @(negedge clk);
    chk(vec_valid && vec_addr == va(3), "R6 source 3 presented", vec_addr, va(3));
    pulse(N'(1) << 11);
    repeat (4) @(negedge clk);
    chk(vec_valid && vec_addr == va(3), "R6 held despite higher request", vec_addr, va(3));
    expect_vec(3, 1); expect_vec(11, 0);
    auto_ack = 1;
    drain("R6 held then next served");

    // R9 set beats clear, clear alone works
    gie = 0;
    src_pulse = N'(1) << 4; tb_clr = 1; tb_mask = N'(1) << 4;
    @(negedge clk);
    src_pulse = '0; tb_clr = 0; tb_mask = '0;
    chk(flags[4], "R9 set wins over clear", flags[4], 1);
    pulse(N'(1) << 5);
    tb_clr = 1; tb_mask = N'(1) << 5;
    @(negedge clk);
    tb_clr = 0; tb_mask = '0;
    chk(flags[4] && !flags[5], "R9 clear only masked flag", flags[5:4], 2'b01);
    tb_clr = 1; tb_mask = N'(1) << 4;
    @(negedge clk);
    tb_clr = 0; tb_mask = '0;
    chk(flags == '0, "R9 software clear", flags, 0);
    gie = 1;

    // R10 pin edge
    expect_vec(14, 0);
    nmi_pin = 1;
    drain("R10 pin edge served");
    repeat (8) @(negedge clk);
    chk(!vec_valid && !flags[14], "R10 level held does not re-set", {vec_valid, flags[14]}, 0);
    nmi_pin = 0;
    repeat (3) @(negedge clk);
    expect_vec(14, 0);
    nmi_pin = 1;
    drain("R10 second edge served");
    nmi_pin = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule